// File: doc/BRIEF.md
# Sized Binary Adder with Condition Flags

This block is the integer add stage of a processor execute pipeline. Each cycle with `in_valid` high it takes a destination value and either a source operand or a small built-in constant. It adds them at byte, word or longword width and registers a 32-bit destination value together with an updated five-bit flag word. Operand fetch and address generation happen upstream. The caller writes the registered result back to the destination register and writes the flag word to the condition register.

Four variants share the adder:

- **Plain add** uses the source operand.
- **Address add** sign-extends a word source, writes all 32 bits and leaves the flags alone.
- **Quick add** uses a 3-bit constant that stands for 1 to 8.
- **Extended add** folds the incoming X flag in as a carry and keeps Z sticky across a chain of partial sums.

When the destination is a data register, the bits above the selected size pass through unchanged.

Top module: `addcc_unit`

Encodings used throughout this brief:

- `op`: 0 plain add, 1 address add, 2 quick add, 3 extended add.
- `size`: 0 byte (8 bits), 1 word (16 bits), 2 or 3 longword (32 bits).
- Flag word: bit 4 X, bit 3 N, bit 2 Z, bit 1 V, bit 0 C.

## Requirements
- R1: With op 0, the low `size` bits of `result` equal the low `size` bits of src plus dst, ignoring the carry out.
- R2: With op 1, a word (or byte-coded) source is sign-extended from bit 15 to 32 bits and added to all 32 bits of dst. For example, 0x00008002 added to 0x00000100 gives 0xFFFF8102. A longword source is added as is.
- R3: With op 1, `flags_out` equals the incoming `flags_in`, whatever the operands.
- R4: With op 2, the addend is the `quick` field value, and a field of 000 means 8; `src` is ignored.
- R5: With op 2 and `dst_is_addr` high, the constant is added to all 32 bits of dst at any size, and the flags are passed through unchanged. With `dst_is_addr` low, op 2 behaves as a data-register add. `dst_is_addr` has no effect on ops 0, 1 and 3.
- R6: For flag-updating operations (ops 0 and 3, and op 2 to a data register), C and X both equal the carry out of the top bit of the selected size, and N equals that top bit of the result.
- R7: For flag-updating operations, V is set exactly when both addends have the same sign at the selected size and the sized result has the other sign.
- R8: With op 3, the incoming X bit is added as a carry-in. Z is cleared when the sized result is non-zero and otherwise keeps its incoming value.
- R9: For ops 0 and 2 to a data register, Z is 1 exactly when the sized result is zero.
- R10: For data-register operations, `result` bits above the selected size equal the corresponding dst bits.
- R11: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise. `result` and `flags_out` change only on such cycles and hold in between. Reset sets all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | Variant: 0 plain, 1 address, 2 quick, 3 extended |
| size | input | 2 | Operand size: 0 byte, 1 word, 2/3 longword |
| dst_is_addr | input | 1 | Destination is an address register (affects quick add only) |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand |
| quick | input | 3 | Quick constant, 000 meaning 8 |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| out_valid | output | 1 | Result and flags registered this cycle |
| result | output | 32 | New destination value |
| flags_out | output | 5 | New flags {X,N,Z,V,C} |

## Verification
The directed cases cover several boundary patterns at each size, and each separates a different kind of fault:

- **Carry past the top bit:** 0xFF plus 1 tells a carry taken from the wrong lane apart from a correct one.
- **Positive overflow:** 0x7F plus 1 separates signed overflow from unsigned carry.
- **Negative plus negative:** 0x80 plus 0x80 sets both C and V.
- **Dirty upper bits:** destinations with non-zero bits above the operand expose a merge that clobbers or leaks them.

Address adds with 0x8002 and 0x7FFF separate sign extension from zero extension. Quick codes 000 and 111 separate the 8 encoding from a literal zero. Extended-add chains with Z entering as 0 and as 1 separate sticky Z from a plainly computed Z. A seeded sweep over every variant, size and destination type compares against an independently written model of the requirements.

// File: rtl/addcc_pkg.sv
package addcc_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_LANES = 3;
    localparam int QUICK_W   = 3;
    localparam int HALF_W    = DATA_W / 2;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'd0,
        OP_ADDR  = 2'd1,
        OP_QUICK = 2'd2,
        OP_EXT   = 2'd3
    } add_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_ALT  = 2'd3
    } add_size_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic carry;
        logic neg;
        logic zero;
        logic ovf;
    } lane_stat_t;

    function automatic logic [DATA_W-1:0] quick_value(input logic [QUICK_W-1:0] q);
        logic [DATA_W-1:0] v;
        v = {{(DATA_W-QUICK_W){1'b0}}, q};
        if (q == '0) v = DATA_W'(1 << QUICK_W);
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] sext_half(input logic [DATA_W-1:0] a);
        return {{(DATA_W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
    endfunction

    function automatic logic [1:0] lane_of(input add_size_e s);
        logic [1:0] idx;
        case (s)
            SZ_BYTE: idx = 2'd0;
            SZ_WORD: idx = 2'd1;
            default: idx = 2'd2;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/addcc_operand.sv
module addcc_operand
    import addcc_pkg::*;
(
    input  add_op_e             op,
    input  add_size_e           size,
    input  logic                dst_is_addr,
    input  logic [DATA_W-1:0]   src,
    input  logic [QUICK_W-1:0]  quick,
    output logic                addr_path,
    output logic [DATA_W-1:0]   addend
);
    logic [DATA_W-1:0] raw;
    logic              is_long;

    always_comb begin
        raw       = (op == OP_QUICK) ? quick_value(quick) : src;
        addr_path = (op == OP_ADDR) || ((op == OP_QUICK) && dst_is_addr);
        is_long   = (size == SZ_LONG) || (size == SZ_ALT);
        if (addr_path && !is_long) addend = sext_half(raw);
        else                       addend = raw;
    end
endmodule

// File: rtl/addcc_core.sv
module addcc_core
    import addcc_pkg::*;
(
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic                cin,
    input  logic                full_width,
    input  add_size_e           size,
    output logic [DATA_W-1:0]   sum_out,
    output lane_stat_t          stat
);
    logic [DATA_W-1:0] lane_res  [NUM_LANES];
    lane_stat_t        lane_stat [NUM_LANES];
    logic [1:0]        sel;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int W = 8 << i;
        logic [W:0] s;
        assign s = {1'b0, a[W-1:0]} + {1'b0, b[W-1:0]} + {{W{1'b0}}, cin};
        assign lane_stat[i].carry = s[W];
        assign lane_stat[i].neg   = s[W-1];
        assign lane_stat[i].zero  = (s[W-1:0] == '0);
        assign lane_stat[i].ovf   = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
        if (W < DATA_W) begin : g_merge
            assign lane_res[i] = {b[DATA_W-1:W], s[W-1:0]};
        end else begin : g_full
            assign lane_res[i] = s[W-1:0];
        end
    end

    always_comb begin
        sel     = full_width ? 2'(NUM_LANES-1) : lane_of(size);
        sum_out = lane_res[sel];
        stat    = lane_stat[sel];
    end
endmodule

// File: rtl/addcc_flags.sv
module addcc_flags
    import addcc_pkg::*;
(
    input  add_op_e     op,
    input  logic        addr_path,
    input  ccr_t        ccr_in,
    input  lane_stat_t  stat,
    output ccr_t        ccr_out
);
    always_comb begin
        if (addr_path) begin
            ccr_out = ccr_in;
        end else begin
            ccr_out.x = stat.carry;
            ccr_out.c = stat.carry;
            ccr_out.n = stat.neg;
            ccr_out.v = stat.ovf;
            if (op == OP_EXT) ccr_out.z = ccr_in.z & stat.zero;
            else              ccr_out.z = stat.zero;
        end
    end
endmodule

// File: rtl/addcc_unit.sv
module addcc_unit
    import addcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  op,
    input  logic [1:0]  size,
    input  logic        dst_is_addr,
    input  logic [31:0] src,
    input  logic [31:0] dst,
    input  logic [2:0]  quick,
    input  logic [4:0]  flags_in,
    output logic        out_valid,
    output logic [31:0] result,
    output logic [4:0]  flags_out
);
    add_op_e           op_e;
    add_size_e         size_e;
    ccr_t              ccr_in;
    ccr_t              ccr_next;
    logic              addr_path;
    logic [DATA_W-1:0] addend;
    logic [DATA_W-1:0] sum;
    lane_stat_t        stat;
    logic              cin;

    assign op_e   = add_op_e'(op);
    assign size_e = add_size_e'(size);
    assign ccr_in = ccr_t'(flags_in);
    assign cin    = (op_e == OP_EXT) ? ccr_in.x : 1'b0;

    addcc_operand u_operand (
        .op          (op_e),
        .size        (size_e),
        .dst_is_addr (dst_is_addr),
        .src         (src),
        .quick       (quick),
        .addr_path   (addr_path),
        .addend      (addend)
    );

    addcc_core u_core (
        .a          (addend),
        .b          (dst),
        .cin        (cin),
        .full_width (addr_path),
        .size       (size_e),
        .sum_out    (sum),
        .stat       (stat)
    );

    addcc_flags u_flags (
        .op        (op_e),
        .addr_path (addr_path),
        .ccr_in    (ccr_in),
        .stat      (stat),
        .ccr_out   (ccr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= sum;
                flags_out <= ccr_next;
            end
        end
    end
endmodule

// File: rtl/addcc_checker.sv
module addcc_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  op,
    input logic [1:0]  size,
    input logic        dst_is_addr,
    input logic [31:0] src,
    input logic [31:0] dst,
    input logic [2:0]  quick,
    input logic [4:0]  flags_in,
    input logic        out_valid,
    input logic [31:0] result,
    input logic [4:0]  flags_out
);
    logic data_dst;
    logic [31:0] qval;
    assign data_dst = (op != 2'd1) && !((op == 2'd2) && dst_is_addr);
    assign qval     = (quick == 3'd0) ? 32'd8 : {29'd0, quick};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                          // R11
    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out))); // R11
    AST_ADDR_LONG_SUM: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd1 && size[1]) |=> result == $past(dst) + $past(src)); // R2
    AST_ADDR_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd1) |=> flags_out == $past(flags_in));       // R3
    AST_QUICK_ADDR_SUM: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd2 && dst_is_addr) |=> result == $past(dst) + $past(qval)); // R4
    AST_QUICK_ADDR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd2 && dst_is_addr) |=> flags_out == $past(flags_in)); // R5
    AST_X_TRACKS_C: assert property (@(posedge clk) disable iff (rst)
        (in_valid && data_dst) |=> flags_out[4] == flags_out[0]);         // R6
    AST_EXT_Z_STICKY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd3 && !flags_in[2]) |=> !flags_out[2]);      // R8
    AST_BYTE_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && data_dst && size == 2'd0) |=> result[31:8] == $past(dst[31:8])); // R10
    AST_WORD_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && data_dst && size == 2'd1) |=> result[31:16] == $past(dst[31:16])); // R10
endmodule

bind addcc_unit addcc_checker u_addcc_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .op          (op),
    .size        (size),
    .dst_is_addr (dst_is_addr),
    .src         (src),
    .dst         (dst),
    .quick       (quick),
    .flags_in    (flags_in),
    .out_valid   (out_valid),
    .result      (result),
    .flags_out   (flags_out)
);

// File: tb/addcc_unit_bench.sv
module addcc_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic [1:0]  size;
    logic        dst_is_addr;
    logic [31:0] src;
    logic [31:0] dst;
    logic [2:0]  quick;
    logic [4:0]  flags_in;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  flags_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    addcc_unit u_addcc_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
        .dst_is_addr(dst_is_addr), .src(src), .dst(dst), .quick(quick),
        .flags_in(flags_in), .out_valid(out_valid), .result(result),
        .flags_out(flags_out)
    );

    // Model written from the requirements. Flags {X,N,Z,V,C}.
    function automatic void model(input logic [1:0] o, input logic [1:0] s,
                                  input logic ad, input logic [31:0] a,
                                  input logic [31:0] d, input logic [2:0] q,
                                  input logic [4:0] fi,
                                  output logic [31:0] r, output logic [4:0] fo);
        int          w;
        logic [31:0] mask, sb, x, rl;
        logic [63:0] t;
        logic        cy, ng, zz, vv;
        w    = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        sb   = 32'h1 << (w - 1);
        x    = (o == 2'd2) ? ((q == 3'd0) ? 32'd8 : {29'd0, q}) : a;
        if (o == 2'd1 || (o == 2'd2 && ad)) begin
            if (w != 32) x = {{16{x[15]}}, x[15:0]};
            r  = d + x;
            fo = fi;
        end else begin
            t  = {32'd0, x & mask} + {32'd0, d & mask} + ((o == 2'd3) ? {63'd0, fi[4]} : 64'd0);
            rl = t[31:0] & mask;
            cy = t[w];
            ng = (rl & sb) != 0;
            vv = (((x & sb) != 0) == ((d & sb) != 0)) && (((rl & sb) != 0) != ((x & sb) != 0));
            zz = (o == 2'd3) ? (fi[2] && rl == 0) : (rl == 0);
            r  = (d & ~mask) | rl;
            fo = {cy, ng, zz, vv, cy};
        end
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one operation at a falling edge; outputs are sampled one falling edge later.
    task automatic issue(input logic [1:0] o, input logic [1:0] s, input logic ad,
                         input logic [31:0] a, input logic [31:0] d,
                         input logic [2:0] q, input logic [4:0] fi);
        @(negedge clk);
        in_valid = 1'b1; op = o; size = s; dst_is_addr = ad;
        src = a; dst = d; quick = q; flags_in = fi;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic op_check(input string tag, input logic [1:0] o, input logic [1:0] s,
                            input logic ad, input logic [31:0] a, input logic [31:0] d,
                            input logic [2:0] q, input logic [4:0] fi);
        logic [31:0] er;
        logic [4:0]  ef;
        model(o, s, ad, a, d, q, fi, er, ef);
        issue(o, s, ad, a, d, q, fi);
        check({tag, " result"}, result, er);
        check({tag, " flags"}, {27'd0, flags_out}, {27'd0, ef});
        check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    endtask

    task automatic t_reset();
        check("R11 reset valid", {31'd0, out_valid}, 32'd0);
        check("R11 reset result", result, 32'd0);
        check("R11 reset flags", {27'd0, flags_out}, 32'd0);
    endtask

    task automatic t_plain();
        // Byte 0xFF+1: carry, zero, upper dst bits kept (R1 R6 R9 R10)
        issue(2'd0, 2'd0, 1'b0, 32'h0000_0001, 32'hABCD_12FF, 3'd0, 5'b00000);
        check("R10 byte upper keep", result, 32'hABCD_1200);
        check("R6 R9 byte carry zero", {27'd0, flags_out}, {27'd0, 5'b10101});
        // Byte 0x7F+1: overflow, negative, no carry (R7)
        issue(2'd0, 2'd0, 1'b0, 32'h0000_0001, 32'h5555_557F, 3'd0, 5'b11111);
        check("R1 byte sum", result, 32'h5555_5580);
        check("R7 byte overflow", {27'd0, flags_out}, {27'd0, 5'b01010});
        op_check("R7 byte neg plus neg", 2'd0, 2'd0, 1'b0, 32'h80, 32'hFFFF_FF80, 3'd0, 5'b0);
        op_check("R1 word", 2'd0, 2'd1, 1'b0, 32'h1234_7FFF, 32'h9999_0001, 3'd0, 5'b0);
        op_check("R6 word carry", 2'd0, 2'd1, 1'b1, 32'h0000_8000, 32'h7777_8000, 3'd0, 5'b0);
        op_check("R1 long", 2'd0, 2'd2, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 3'd0, 5'b0);
        op_check("R9 long zero", 2'd0, 2'd3, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 3'd0, 5'b0);
    endtask

    task automatic t_addr();
        issue(2'd1, 2'd1, 1'b0, 32'h0000_8002, 32'h0000_0100, 3'd0, 5'b10110);
        check("R2 word sign extend", result, 32'hFFFF_8102);
        check("R3 flags held", {27'd0, flags_out}, {27'd0, 5'b10110});
        issue(2'd1, 2'd1, 1'b0, 32'hFFFF_7FFF, 32'h0000_0001, 3'd0, 5'b01001);
        check("R2 word positive", result, 32'h0000_8000);
        check("R3 flags held 2", {27'd0, flags_out}, {27'd0, 5'b01001});
        op_check("R2 long", 2'd1, 2'd2, 1'b0, 32'h8000_0000, 32'h8000_0000, 3'd0, 5'b00100);
    endtask

    task automatic t_quick();
        issue(2'd2, 2'd0, 1'b0, 32'hDEAD_BEEF, 32'h0000_00F8, 3'd0, 5'b00000);
        check("R4 code 000 is 8", result, 32'h0000_0000);
        check("R4 R9 flags", {27'd0, flags_out}, {27'd0, 5'b10101});
        issue(2'd2, 2'd1, 1'b1, 32'h0, 32'h0000_FFFF, 3'd7, 5'b01010);
        check("R5 address word full 32", result, 32'h0001_0006);
        check("R5 flags held", {27'd0, flags_out}, {27'd0, 5'b01010});
        op_check("R5 quick data word", 2'd2, 2'd1, 1'b0, 32'h0, 32'h1234_FFFF, 3'd1, 5'b0);
        op_check("R5 ignored on plain", 2'd0, 2'd0, 1'b1, 32'h1, 32'h0000_0010, 3'd0, 5'b0);
    endtask

    task automatic t_ext();
        // Chain: Z enters 1, first partial zero keeps it, second non-zero clears it.
        issue(2'd3, 2'd0, 1'b0, 32'h0000_00FF, 32'h0000_0000, 3'd0, 5'b10100);
        check("R8 x carry-in", result, 32'h0000_0000);
        check("R8 z kept", {27'd0, flags_out}, {27'd0, 5'b10101});
        issue(2'd3, 2'd0, 1'b0, 32'h0, 32'h0, 3'd0, flags_out);
        check("R8 chain sum", result, 32'h0000_0001);
        check("R8 z cleared", {27'd0, flags_out}, {27'd0, 5'b00000});
        issue(2'd3, 2'd1, 1'b0, 32'h0, 32'h0, 3'd0, 5'b00000);
        check("R8 zero with z in 0", {27'd0, flags_out}, {27'd0, 5'b00000});
        op_check("R8 long", 2'd3, 2'd2, 1'b0, 32'hFFFF_FFFF, 32'h0, 3'd0, 5'b10100);
    endtask

    task automatic t_hold();
        logic [31:0] r0;
        logic [4:0]  f0;
        r0 = result; f0 = flags_out;
        @(negedge clk);
        op = 2'd0; src = 32'h1111_1111; dst = 32'h2222_2222;
        @(negedge clk);
        check("R11 valid low idle", {31'd0, out_valid}, 32'd0);
        check("R11 result held", result, r0);
        check("R11 flags held", {27'd0, flags_out}, {27'd0, f0});
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 400; i++) begin
            op_check("R1 R6 R7 sweep", 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                     1'($urandom_range(0, 1)), $urandom, $urandom,
                     3'($urandom_range(0, 7)), 5'($urandom_range(0, 31)));
        end
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = '0; size = '0; dst_is_addr = 1'b0;
        src = '0; dst = '0; quick = '0; flags_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_addr();
        t_quick();
        t_ext();
        t_hold();
        void'($urandom(32'd7));
        t_sweep();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule